// File: doc/BRIEF.md
# Sound Peripheral Bus Register Interface

This block sits between an 8-bit microprocessor bus and the synthesis core of a sound peripheral. It watches a chip-select line, a read/write line, a 5-bit address and a bus clock phase. Transfers are accepted only inside the high half of the bus phase. Writes land in a bank of 25 configuration bytes that the synthesis core reads in parallel. Reads return one of four status bytes that the core supplies on input ports. The 11-bit filter cutoff, built from two of the configuration bytes, is presented on its own output.

All logic runs on a fast system clock that oversamples the bus phase. A write takes effect once per bus cycle, when the phase window closes, however many fast-clock periods the window lasts. The active-low reset is filtered. Only a low level held across ten bus-cycle ends clears the bank, clears the held bus value and mutes the audio. A shorter glitch leaves everything as it was. The mute output stays asserted until software writes a configuration byte.

Top module: `sndbus_regif`

## Requirements
- R1: No register changes unless a bus window occurs with `cs_n` low while `bus_phase` is high. Driving `cs_n` low with `bus_phase` low, or running a window with `cs_n` high, leaves `cfg_regs` unchanged.
- R2: `doe` is high only while `cs_n` is low, `bus_phase` is high and `rw` is high (read). `doe` is low during writes and when the bus is idle.
- R3: A write (`rw` low) to address 0x00..0x18 stores `din` into byte `addr` of `cfg_regs` (bits `addr*8+7 : addr*8`). The byte is visible once the phase window has closed, and exactly one store happens per window whatever its length.
- R4: A read of address 0x19..0x1C drives `dout` with byte (`addr`-0x19) of `ro_vals`.
- R5: Writes to addresses 0x19..0x1F change no byte of `cfg_regs`.
- R6: A read of address 0x00..0x18 returns the byte last carried on the bus by a completed transfer: the data of the last write, or the data returned by the last read.
- R7: `filt_cutoff` equals {byte 0x16, byte 0x15 bits 2:0}. Bits 7:3 of byte 0x15 have no effect on it.
- R8: If `rst_n` stays low across 10 consecutive bus-cycle ends (falling edges of `bus_phase`), all of `cfg_regs`, the held bus value and `filt_cutoff` become zero and `mute` becomes 1, for as long as `rst_n` stays low.
- R9: A low pulse on `rst_n` spanning fewer than 10 bus-cycle ends leaves all registers and `mute` unchanged. The count restarts each time `rst_n` returns high, so two short pulses do not add up.
- R10: After a reset, `mute` falls at the first completed write to a configuration address (0x00..0x18). Writes to 0x19..0x1F leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples the bus |
| rst_n | input | 1 | Active-low reset request, filtered over bus cycles |
| bus_phase | input | 1 | Bus clock phase; high marks the transfer window |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Register address |
| din | input | 8 | Data bus, inbound |
| dout | output | 8 | Data bus, outbound |
| doe | output | 1 | Data bus drive enable |
| ro_vals | input | 32 | Four status bytes, byte k at address 0x19+k |
| cfg_regs | output | 200 | Configuration bytes, byte n at bits n*8+7:n*8 |
| filt_cutoff | output | 11 | Assembled filter cutoff |
| mute | output | 1 | Audio mute, set by reset |

## Verification
A vector table writes single bytes at the bottom, middle and top of the configuration range, including a later overwrite of an earlier entry. It also writes with a stretched window, which separates a one-store-per-window design from one that stores on every fast clock. Reads of every status address tell a correct offset apart from an off-by-one. Reads of configuration addresses placed after a write and after a status read show whether the held bus value follows both directions. Reset is driven as a full-length hold, as two short pulses separated by a release, and as writes to unimplemented addresses before the first real write. Together these show whether the counter accumulates across releases and whether the mute reacts to the wrong address range.

// File: rtl/sndbus_pkg.sv
package sndbus_pkg;

  localparam int unsigned CUT_W = 11;

  typedef enum logic [1:0] {
    SLOT_CFG  = 2'd0,
    SLOT_STAT = 2'd1,
    SLOT_NONE = 2'd2
  } slot_e;

  // Classify an address into configuration, status or unimplemented space.
  function automatic slot_e slot_of(input int unsigned a,
                                    input int unsigned n_cfg,
                                    input int unsigned n_stat);
    if (a < n_cfg)               return SLOT_CFG;
    else if (a < n_cfg + n_stat) return SLOT_STAT;
    else                         return SLOT_NONE;
  endfunction

  // Eight high bits from the upper byte, three low bits from the lower byte.
  function automatic logic [CUT_W-1:0] cutoff_join(input logic [7:0] lo,
                                                   input logic [7:0] hi);
    return {hi, lo[2:0]};
  endfunction

endpackage

// File: rtl/sndbus_xfer.sv
module sndbus_xfer #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          bus_phase,
  input  logic          cs_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] rd_data,
  output logic          qual_rd,
  output logic          win_end,
  output logic          commit,
  output logic          commit_wr,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data
);

  logic phase_q;
  logic cap_vld;
  logic cap_rw;
  logic qual;

  assign qual      = !cs_n && bus_phase;
  assign qual_rd   = qual && rw;
  assign win_end   = phase_q && !bus_phase;
  assign commit    = win_end && cap_vld;
  assign commit_wr = commit && !cap_rw;

  always_ff @(posedge clk) begin
    phase_q <= bus_phase;
  end

  // Hold the latest qualified request of the window until the window closes.
  always_ff @(posedge clk) begin
    if (clr || win_end) begin
      cap_vld <= 1'b0;
    end else if (qual) begin
      cap_vld  <= 1'b1;
      cap_rw   <= rw;
      cap_addr <= addr;
      cap_data <= rw ? rd_data : din;
    end
  end

endmodule

// File: rtl/sndbus_rstgate.sv
module sndbus_rstgate #(
  parameter int RST_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_end,
  output logic in_reset
);

  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(RST_CYCLES);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst_n) begin
      low_cnt <= '0;
    end else if (bus_end && low_cnt != FULL) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign in_reset = !rst_n && (low_cnt == FULL);

endmodule

// File: rtl/sndbus_regfile.sv
module sndbus_regfile #(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int N_CFG = 25
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  output logic [N_CFG*DW-1:0] cfg_flat
);

  for (genvar g = 0; g < N_CFG; g++) begin : g_byte
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (clr) begin
        q <= '0;
      end else if (we && waddr == AW'(g)) begin
        q <= wdata;
      end
    end
    assign cfg_flat[g*DW +: DW] = q;
  end

endmodule

// File: rtl/sndbus_regif.sv
module sndbus_regif
  import sndbus_pkg::*;
#(
  parameter int AW         = 5,
  parameter int DW         = 8,
  parameter int N_CFG      = 25,
  parameter int N_STAT     = 4,
  parameter int RST_CYCLES = 10,
  parameter int CUT_LO     = 21,
  parameter int CUT_HI     = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_phase,
  input  logic                 cs_n,
  input  logic                 rw,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        din,
  output logic [DW-1:0]        dout,
  output logic                 doe,
  input  logic [N_STAT*DW-1:0] ro_vals,
  output logic [N_CFG*DW-1:0]  cfg_regs,
  output logic [CUT_W-1:0]     filt_cutoff,
  output logic                 mute
);

  logic          in_reset;
  logic          qual_rd;
  logic          win_end;
  logic          commit;
  logic          commit_wr;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] bus_hold;
  logic          wo_write;
  slot_e         cap_slot;

  sndbus_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk       (clk),
    .clr       (in_reset),
    .bus_phase (bus_phase),
    .cs_n      (cs_n),
    .rw        (rw),
    .addr      (addr),
    .din       (din),
    .rd_data   (rd_data),
    .qual_rd   (qual_rd),
    .win_end   (win_end),
    .commit    (commit),
    .commit_wr (commit_wr),
    .cap_addr  (cap_addr),
    .cap_data  (cap_data)
  );

  sndbus_rstgate #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_end  (win_end),
    .in_reset (in_reset)
  );

  assign cap_slot = slot_of(32'(cap_addr), N_CFG, N_STAT);
  assign wo_write = commit_wr && (cap_slot == SLOT_CFG) && !in_reset;

  sndbus_regfile #(.AW(AW), .DW(DW), .N_CFG(N_CFG)) u_regs (
    .clk      (clk),
    .clr      (in_reset),
    .we       (wo_write),
    .waddr    (cap_addr),
    .wdata    (cap_data),
    .cfg_flat (cfg_regs)
  );

  // Read path: status bytes by address, everything else returns the held bus byte.
  always_comb begin
    rd_data = bus_hold;
    for (int k = 0; k < N_STAT; k++) begin
      if (addr == AW'(N_CFG + k)) begin
        rd_data = ro_vals[k*DW +: DW];
      end
    end
  end

  assign dout = rd_data;
  assign doe  = qual_rd;

  always_ff @(posedge clk) begin
    if (in_reset) begin
      bus_hold <= '0;
    end else if (commit) begin
      bus_hold <= cap_data;
    end
  end

  always_ff @(posedge clk) begin
    if (in_reset) begin
      mute <= 1'b1;
    end else if (wo_write) begin
      mute <= 1'b0;
    end
  end

  assign filt_cutoff = cutoff_join(cfg_regs[CUT_LO*DW +: 8], cfg_regs[CUT_HI*DW +: 8]);

endmodule

// File: rtl/sndbus_regif_chk.sv
module sndbus_regif_chk #(
  parameter int N_CFG = 25,
  parameter int DW    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               rw,
  input logic               doe,
  input logic               mute,
  input logic [N_CFG*DW-1:0] cfg_regs,
  input logic               in_reset,
  input logic               commit,
  input logic               wo_write
);

  // R2: never drive the bus on a write or when not selected
  a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw || cs_n) |-> !doe);

  // R3: one completed transfer per window
  a_r3_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R8: a held reset clears the bank and mutes
  a_r8_cleared: assert property (@(posedge clk) disable iff (rst_n)
    in_reset |=> (cfg_regs == '0 && mute));

  // R9 (also R1, R5): contents move only on a configuration write
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wo_write |=> $stable(cfg_regs));

  // R10: mute falls only after a configuration write
  a_r10_unmute_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> $past(wo_write));

endmodule

bind sndbus_regif sndbus_regif_chk #(.N_CFG(N_CFG), .DW(DW)) chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .rw       (rw),
  .doe      (doe),
  .mute     (mute),
  .cfg_regs (cfg_regs),
  .in_reset (in_reset),
  .commit   (commit),
  .wo_write (wo_write)
);

// File: tb/sndbus_regif_test.sv
module sndbus_regif_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_phase = 1'b0;
  logic         cs_n = 1'b1;
  logic         rw = 1'b1;
  logic [4:0]   addr = '0;
  logic [7:0]   din = '0;
  logic [7:0]   dout;
  logic         doe;
  logic [31:0]  ro_vals = {8'hC4, 8'h7B, 8'h3E, 8'h91};
  logic [199:0] cfg_regs;
  logic [10:0]  filt_cutoff;
  logic         mute;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sndbus_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .cs_n(cs_n), .rw(rw),
    .addr(addr), .din(din), .dout(dout), .doe(doe), .ro_vals(ro_vals),
    .cfg_regs(cfg_regs), .filt_cutoff(filt_cutoff), .mute(mute)
  );

  // {address, data}
  localparam logic [12:0] VEC [0:7] = '{
    {5'h00, 8'h12}, {5'h04, 8'hFF}, {5'h0B, 8'h80}, {5'h11, 8'h01},
    {5'h18, 8'hA7}, {5'h15, 8'hFD}, {5'h16, 8'hA5}, {5'h04, 8'h3C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] cbyte(input int a);
    return cfg_regs[a*8 +: 8];
  endfunction

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d, input int hi = 3);
    @(negedge clk);
    bus_phase = 1'b1; cs_n = 1'b0; rw = 1'b0; addr = a; din = d;
    cyc(hi);
    bus_phase = 1'b0; cs_n = 1'b1; rw = 1'b1;
    cyc(3);
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    bus_phase = 1'b1; cs_n = 1'b0; rw = 1'b1; addr = a;
    cyc(1);
    d = dout; oe = doe;
    cyc(2);
    bus_phase = 1'b0; cs_n = 1'b1;
    cyc(3);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bus_phase = 1'b1;
      cyc(3); bus_phase = 1'b0;
      cyc(3);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    logic [199:0] snap;

    // R8: reset held for 12 bus cycles
    rst_n = 1'b0;
    idle(12);
    chk("R8 cfg cleared", 32'(cfg_regs == '0), 1);
    chk("R8 mute set", 32'(mute), 1);
    chk("R8 cutoff zero", 32'(filt_cutoff), 0);
    chk("R2 idle no drive", 32'(doe), 0);
    rst_n = 1'b1;
    idle(1);

    // R10: unimplemented and status writes keep mute; config write clears it
    bus_wr(5'h1E, 8'h77);
    bus_wr(5'h1B, 8'h66);
    chk("R10 mute kept after non-config writes", 32'(mute), 1);
    bus_wr(5'h02, 8'h00);
    chk("R10 mute cleared by config write", 32'(mute), 0);

    // R3: vector table, entry 3 uses a stretched window
    for (int i = 0; i < 8; i++) begin
      bus_wr(VEC[i][12:8], VEC[i][7:0], (i == 3) ? 9 : 3);
      chk("R3 table write", 32'(cbyte(int'(VEC[i][12:8]))), 32'(VEC[i][7:0]));
    end
    chk("R3 overwritten earlier byte", 32'(cbyte(4)), 32'h3C);

    // R7: {A5, 101} = 0x52D; upper bits of the low byte ignored
    chk("R7 cutoff", 32'(filt_cutoff), 32'h52D);
    bus_wr(5'h15, 8'h05);
    chk("R7 low byte stored", 32'(cbyte(21)), 32'h05);
    chk("R7 cutoff ignores bits 7:3", 32'(filt_cutoff), 32'h52D);

    // R4 / R2: status reads
    for (int k = 0; k < 4; k++) begin
      bus_rd(5'(25 + k), rd, oe);
      chk("R4 status read", 32'(rd), 32'(ro_vals[k*8 +: 8]));
      chk("R2 drive on read", 32'(oe), 1);
    end

    // R2: no drive inside a write window
    @(negedge clk);
    bus_phase = 1'b1; cs_n = 1'b0; rw = 1'b0; addr = 5'h09; din = 8'h44;
    cyc(1);
    chk("R2 no drive on write", 32'(doe), 0);
    cyc(2);
    bus_phase = 1'b0; cs_n = 1'b1; rw = 1'b1;
    cyc(3);

    // R6: held bus value after write and after status read
    bus_wr(5'h03, 8'h5A);
    bus_rd(5'h07, rd, oe);
    chk("R6 read returns last written", 32'(rd), 32'h5A);
    bus_rd(5'h1A, rd, oe);
    bus_rd(5'h00, rd, oe);
    chk("R6 read returns last read", 32'(rd), 32'h3E);

    // R5: writes above the configuration range change nothing
    snap = cfg_regs;
    bus_wr(5'h19, 8'hEE);
    bus_wr(5'h1D, 8'hEE);
    bus_wr(5'h1F, 8'hEE);
    chk("R5 cfg unchanged", 32'(cfg_regs == snap), 1);

    // R1: unselected window, and select without phase
    @(negedge clk);
    bus_phase = 1'b1; cs_n = 1'b1; rw = 1'b0; addr = 5'h00; din = 8'hEE;
    cyc(3);
    bus_phase = 1'b0; rw = 1'b1;
    cyc(3);
    chk("R1 unselected window ignored", 32'(cbyte(0)), 32'h12);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; addr = 5'h00; din = 8'hEE;
    cyc(5);
    cs_n = 1'b1; rw = 1'b1;
    idle(1);
    chk("R1 select without phase ignored", 32'(cbyte(0)), 32'h12);

    // R9: two short pulses separated by a release
    snap = cfg_regs;
    rst_n = 1'b0; idle(6);
    rst_n = 1'b1; idle(1);
    rst_n = 1'b0; idle(6);
    rst_n = 1'b1; idle(1);
    chk("R9 short pulses keep contents", 32'(cfg_regs == snap), 1);
    chk("R9 short pulses keep mute", 32'(mute), 0);

    // R8: full reset with populated bank, then held value cleared
    rst_n = 1'b0;
    idle(12);
    chk("R8 full reset clears bank", 32'(cfg_regs == '0), 1);
    chk("R8 full reset mutes", 32'(mute), 1);
    chk("R8 full reset cutoff", 32'(filt_cutoff), 0);
    rst_n = 1'b1;
    idle(1);
    bus_rd(5'h05, rd, oe);
    chk("R8 held bus value cleared", 32'(rd), 0);

    finish_run();
  end

endmodule